// File: doc/BRIEF.md
# Hybrid Five-Level Phase Switch Selector

This block drives the six power switches of one phase of a hybrid cascaded inverter. The bottom leg holds two switches and is fed from the DC bus. An H-bridge is placed in series with it and is fed from a floating capacitor that should sit at half the bus voltage. The bottom leg contributes plus or minus half the bus voltage. The bridge adds plus half, minus half, or zero. The sum of the two gives five phase levels, from minus the bus voltage to plus the bus voltage, in steps of half the bus.

A modulator asserts `step_i` once per modulation step. With the strobe it presents a signed level command, the sign of the phase current and a comparator flag that is high when the capacitor is below its target. On that edge the block registers a new gate pattern. A zero level can be built in two ways, and the two ways draw current through the capacitor in opposite directions. The block picks the one that pushes the capacitor toward its target. Between strobes the pattern is held, so the flags cannot change the choice partway through a step.

Top module: `hyb5_phase_selector`

## Requirements
- R1: After reset all six gate outputs are 0, and they stay 0 until the first step strobe that carries an in-range command.
- R2: Gate bit k-1 drives switch Sk. `level_i` is a 3-bit two's-complement command whose accepted range is -2..+2. +2 gives S1, S4, S5 on (6'b011001). -2 gives S2, S3, S6 on (6'b100110).
- R3: +1 gives S5 with the bridge zero pair S3, S4 (6'b011100). -1 gives S6 with S3, S4 (6'b101100).
- R4: Zero command with positive current (`cur_pos_i`=1): if the capacitor is low (`cap_low_i`=1), the charging set S2, S3, S5 is used (6'b010110). Otherwise the discharging set S1, S4, S6 is used (6'b101001).
- R5: Zero command with negative current (`cur_pos_i`=0): the roles swap. A low capacitor gives 6'b101001, and otherwise the block gives 6'b010110.
- R6: The outputs change only on the edge where `step_i` is high with an in-range command. Changes to the level, current-sign or capacitor inputs between strobes have no effect.
- R7: A strobe carrying an out-of-range command (+3, -3, -4) is ignored, and the outputs keep their previous value.
- R8: Once a command has been accepted, exactly one of S5 and S6 is on. S1 and S3 are never on together, and neither are S2 and S4.
- R9: After an accepted command, the bottom-leg contribution (+1 for S5, -1 for S6) plus the bridge contribution (+1 for S1 with S4, -1 for S2 with S3, 0 otherwise) equals the command.
- R10: The new pattern appears on the outputs at the first rising clock edge at which the strobe is sampled high. Before that edge the old pattern remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Modulation step strobe |
| level_i | input | 3 | Signed level command in half-bus units |
| cur_pos_i | input | 1 | 1 when the phase current is positive |
| cap_low_i | input | 1 | 1 when the capacitor is below half the bus voltage |
| gates_o | output | 6 | Switch enables, bit k-1 is Sk |

## Verification
Two things can happen on the same clock edge: the step capture freezes the flags, and the flags themselves change. This matters when the current sign or the capacitor comparison flips in the very cycle the strobe is high. The bench drives a zero command together with a flag pair and then flips both flags on the following cycles without a strobe. It judges that the registered set still matches the pair present at the strobe edge. A later strobe with the new pair must then move the output to the other set.

// File: rtl/hyb5_pkg.sv
package hyb5_pkg;

  localparam int GATE_N = 6;

  // Redundant zero-voltage sets: A = S1,S4,S6 ; B = S2,S3,S5
  typedef enum logic {ZSET_A = 1'b0, ZSET_B = 1'b1} zset_e;

  localparam logic [GATE_N-1:0] PAT_ZERO_A = 6'b101001;
  localparam logic [GATE_N-1:0] PAT_ZERO_B = 6'b010110;
  localparam logic [GATE_N-1:0] PAT_POS2   = 6'b011001;
  localparam logic [GATE_N-1:0] PAT_NEG2   = 6'b100110;
  localparam logic [GATE_N-1:0] PAT_POS1   = 6'b011100;
  localparam logic [GATE_N-1:0] PAT_NEG1   = 6'b101100;

  // Level (half-bus units) plus zero-set choice -> switch pattern
  function automatic logic [GATE_N-1:0] gates_for(input int lvl, input zset_e z);
    logic [GATE_N-1:0] g;
    case (lvl)
      2:       g = PAT_POS2;
      1:       g = PAT_POS1;
      0:       g = (z == ZSET_A) ? PAT_ZERO_A : PAT_ZERO_B;
      -1:      g = PAT_NEG1;
      -2:      g = PAT_NEG2;
      default: g = '0;
    endcase
    return g;
  endfunction

  // Decode a pattern back to a phase level: bottom leg plus bridge
  function automatic int phase_units(input logic [GATE_N-1:0] g);
    int leg;
    int hb;
    leg = g[4] ? 1 : -1;
    if (g[0] && g[3])      hb = 1;
    else if (g[1] && g[2]) hb = -1;
    else                   hb = 0;
    return leg + hb;
  endfunction

endpackage

// File: rtl/hyb5_range_check.sv
module hyb5_range_check #(
  parameter int LVL_W   = 3,
  parameter int LVL_MAX = 2
) (
  input  logic signed [LVL_W-1:0] lvl_i,
  output logic                    valid_o,
  output logic                    zero_o
);
  localparam int LVL_MIN = -LVL_MAX;

  always_comb begin
    valid_o = (int'(lvl_i) >= LVL_MIN) && (int'(lvl_i) <= LVL_MAX);
    zero_o  = (lvl_i == '0);
  end
endmodule

// File: rtl/hyb5_zero_balancer.sv
module hyb5_zero_balancer
  import hyb5_pkg::*;
(
  input  logic  cur_pos_i,
  input  logic  cap_low_i,
  output zset_e zset_o,
  output logic  charging_o
);
  // With positive current set B charges the capacitor; with negative current set A does.
  zset_e charge_set;

  always_comb begin
    charge_set = cur_pos_i ? ZSET_B : ZSET_A;
    charging_o = cap_low_i;
    if (cap_low_i) zset_o = charge_set;
    else           zset_o = (charge_set == ZSET_B) ? ZSET_A : ZSET_B;
  end
endmodule

// File: rtl/hyb5_gate_encoder.sv
module hyb5_gate_encoder
  import hyb5_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic signed [LVL_W-1:0] lvl_i,
  input  zset_e                   zset_i,
  output logic [GATE_N-1:0]       gates_o
);
  always_comb gates_o = gates_for(int'(lvl_i), zset_i);
endmodule

// File: rtl/hyb5_phase_selector.sv
module hyb5_phase_selector
  import hyb5_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int LVL_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             cur_pos_i,
  input  logic             cap_low_i,
  output logic [5:0]       gates_o
);
  logic signed [LVL_W-1:0] lvl_s;
  logic                    cmd_valid;
  logic                    zero_cmd;
  logic                    step_take;
  logic                    charging;
  zset_e                   zset;
  logic [GATE_N-1:0]       gates_nxt;
  logic [GATE_N-1:0]       gates_q;

  assign lvl_s = $signed(level_i);

  hyb5_range_check #(.LVL_W(LVL_W), .LVL_MAX(LVL_MAX)) i_range (
    .lvl_i   (lvl_s),
    .valid_o (cmd_valid),
    .zero_o  (zero_cmd)
  );

  hyb5_zero_balancer i_bal (
    .cur_pos_i  (cur_pos_i),
    .cap_low_i  (cap_low_i),
    .zset_o     (zset),
    .charging_o (charging)
  );

  hyb5_gate_encoder #(.LVL_W(LVL_W)) i_enc (
    .lvl_i   (lvl_s),
    .zset_i  (zset),
    .gates_o (gates_nxt)
  );

  // Only a strobe with an in-range command loads a new pattern
  assign step_take = step_i && cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gates_q <= '0;
    else if (step_take) gates_q <= gates_nxt;
  end

  assign gates_o = gates_q;
endmodule

// File: rtl/hyb5_selector_chk.sv
module hyb5_selector_chk
  import hyb5_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step_take,
  input logic                    zero_cmd,
  input logic signed [LVL_W-1:0] lvl_s,
  input logic                    cur_pos_i,
  input logic                    cap_low_i,
  input logic [5:0]              gates_o
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (step_take) armed <= 1'b1;
  end

  a_r1_off_until_first: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> gates_o == '0);

  a_r4_pos_low_charges: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && zero_cmd && cur_pos_i && cap_low_i) |=> gates_o == 6'b010110);

  a_r4_pos_high_discharges: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && zero_cmd && cur_pos_i && !cap_low_i) |=> gates_o == 6'b101001);

  a_r5_neg_low_charges: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && zero_cmd && !cur_pos_i && cap_low_i) |=> gates_o == 6'b101001);

  a_r5_neg_high_discharges: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && zero_cmd && !cur_pos_i && !cap_low_i) |=> gates_o == 6'b010110);

  a_r6_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !step_take |=> $stable(gates_o));

  a_r8_one_leg_switch: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $countones(gates_o[5:4]) == 1);

  a_r8_no_bridge_short: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_o[0] && gates_o[2]) && !(gates_o[1] && gates_o[3]));

  a_r9_level_sum: assert property (@(posedge clk) disable iff (!rst_n)
    step_take |=> phase_units(gates_o) == int'($past(lvl_s)));
endmodule

bind hyb5_phase_selector hyb5_selector_chk #(.LVL_W(LVL_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_take (step_take),
  .zero_cmd  (zero_cmd),
  .lvl_s     (lvl_s),
  .cur_pos_i (cur_pos_i),
  .cap_low_i (cap_low_i),
  .gates_o   (gates_o)
);

// File: tb/test_hyb5_phase_selector.sv
module test_hyb5_phase_selector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b0;
  logic [2:0] level_i = 3'b000;
  logic       cur_pos_i = 1'b0;
  logic       cap_low_i = 1'b0;
  logic [5:0] gates_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hyb5_phase_selector i_hyb5_phase_selector (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .level_i(level_i),
    .cur_pos_i(cur_pos_i), .cap_low_i(cap_low_i), .gates_o(gates_o)
  );

  // Expected patterns written from the switch lists (bit k-1 = Sk)
  function automatic logic [5:0] sw(input bit s1, s2, s3, s4, s5, s6);
    return {s6, s5, s4, s3, s2, s1};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    n_chk++;
    if (gates_o !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, gates_o, exp);
    end
  endtask

  task automatic do_step(input int lvl, input bit cur, input bit cap);
    @(negedge clk);
    level_i = 3'(lvl); cur_pos_i = cur; cap_low_i = cap; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset", 6'b0);
    do_step(3, 1, 1);
    check("R1 invalid first step keeps off", 6'b0);
    do_step(-4, 0, 0);
    check("R1 still off", 6'b0);
  endtask

  task automatic t_full_levels;
    do_step(2, 1, 0);  check("R2 +2", sw(1,0,0,1,1,0));
    do_step(-2, 0, 1); check("R2 -2", sw(0,1,1,0,0,1));
    do_step(1, 0, 0);  check("R3 +1", sw(0,0,1,1,1,0));
    do_step(-1, 1, 1); check("R3 -1", sw(0,0,1,1,0,1));
  endtask

  task automatic t_zero;
    do_step(0, 1, 1); check("R4 pos low charge", sw(0,1,1,0,1,0));
    do_step(0, 1, 0); check("R4 pos high discharge", sw(1,0,0,1,0,1));
    do_step(0, 0, 1); check("R5 neg low charge", sw(1,0,0,1,0,1));
    do_step(0, 0, 0); check("R5 neg high discharge", sw(0,1,1,0,1,0));
  endtask

  task automatic t_hold_flags;
    do_step(0, 1, 1);
    check("R6 set at step", sw(0,1,1,0,1,0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cur_pos_i = ~cur_pos_i; cap_low_i = ~cap_low_i; level_i = 3'(k - 2);
    end
    @(negedge clk);
    check("R6 flags ignored between steps", sw(0,1,1,0,1,0));
    do_step(0, 1, 0);
    check("R6 next step moves set", sw(1,0,0,1,0,1));
  endtask

  task automatic t_invalid;
    do_step(2, 1, 1);
    do_step(3, 1, 1);  check("R7 +3 ignored", sw(1,0,0,1,1,0));
    do_step(-3, 0, 0); check("R7 -3 ignored", sw(1,0,0,1,1,0));
    do_step(-4, 1, 0); check("R7 -4 ignored", sw(1,0,0,1,1,0));
  endtask

  task automatic t_latency;
    do_step(-1, 0, 0);
    @(negedge clk);
    level_i = 3'(2); step_i = 1'b1;
    #1 check("R10 old pattern before edge", sw(0,0,1,1,0,1));
    @(negedge clk);
    step_i = 1'b0;
    check("R10 new pattern after edge", sw(1,0,0,1,1,0));
  endtask

  task automatic t_sum;
    // R8/R9: each accepted level decoded at the pins
    for (int l = -2; l <= 2; l++) begin
      int leg;
      int hb;
      do_step(l, l[0], 1'b1);
      leg = gates_o[4] ? 1 : -1;
      hb = (gates_o[0] & gates_o[3]) ? 1 : ((gates_o[1] & gates_o[2]) ? -1 : 0);
      n_chk++;
      if ((leg + hb) != l || (gates_o[4] == gates_o[5])) begin
        n_bad++;
        $display("FAIL R9/R8 level got=%0d exp=%0d gates=%b", leg + hb, l, gates_o);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_levels();
    t_zero();
    t_hold_flags();
    t_invalid();
    t_latency();
    t_sum();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule